// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block sits next to a shared two-port memory and watches both access ports. It reserves the two highest word addresses as mailboxes: the all-ones address belongs to the right port, and the address just below it belongs to the left port. When one port writes into the other port's mailbox, the owner's interrupt flag is raised. It stays raised until the owner reads its own mailbox. The data itself lives in the memory beside the block. The block never sees the message contents.

Each port brings an enable, a write strobe, a read strobe, a word address and the busy flag from the address arbiter. A port whose busy flag is high has lost arbitration. Its mailbox write then sets nothing, and its own-mailbox read clears nothing. Each interrupt output is active low.

Each flag is a two-state machine with the states `FLAG_IDLE` (output high) and `FLAG_PENDING` (output low). It has four transitions:
- **POST**: `FLAG_IDLE` to `FLAG_PENDING` on a valid peer write.
- **ACK**: `FLAG_PENDING` to `FLAG_IDLE` on a valid owner read with no write in the same cycle.
- **REPOST**: `FLAG_PENDING` stays pending on a peer write.
- **HOLD**: the state is unchanged when nothing qualifies.

Top module: `mbox_irq_top`

## Requirements
- R1: With address width AW, the right mailbox is address 2^AW-1 (all ones) and the left mailbox is 2^AW-2.
- R2: An enabled, non-busy left-port write to the right mailbox drives `rt_irq_n` low one clock later.
- R3: An enabled, non-busy right-port write to the left mailbox drives `lt_irq_n` low one clock later.
- R4: An enabled, non-busy read by a port of its own mailbox returns that port's interrupt output to high one clock later.
- R5: A port reading the other port's mailbox leaves that other port's interrupt unchanged.
- R6: A mailbox write from a port whose busy input is high does not set the other port's interrupt.
- R7: An own-mailbox read from a port whose busy input is high does not clear its interrupt.
- R8: Synchronous reset (`rst` high at a clock edge) drives both interrupt outputs high, and they stay high while idle.
- R9: If a flag's set and clear occur in the same cycle, the flag ends up asserted (low).
- R10: The following have no effect on either flag: accesses with enable low, accesses to non-mailbox addresses, and a port writing its own mailbox.
- R11: An access with both write and read strobes high counts as a write only, so it never clears a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lt_en | input | 1 | Left port access enable |
| lt_wr | input | 1 | Left port write strobe |
| lt_rd | input | 1 | Left port read strobe |
| lt_addr | input | AW | Left port word address |
| lt_busy | input | 1 | Left port lost arbitration, active high |
| rt_en | input | 1 | Right port access enable |
| rt_wr | input | 1 | Right port write strobe |
| rt_rd | input | 1 | Right port read strobe |
| rt_addr | input | AW | Right port word address |
| rt_busy | input | 1 | Right port lost arbitration, active high |
| lt_irq_n | output | 1 | Left port interrupt, active low |
| rt_irq_n | output | 1 | Right port interrupt, active low |

## Verification
Every result of this block is due exactly one clock after the access that causes it. Each flag is one register, and the output decodes straight from that register's state. The bench applies an access for a single cycle at a falling edge and removes it at the next falling edge. It samples both interrupt outputs at that same falling edge, half a period after the rising edge that captured the access. Checks that a stimulus had no effect sample at that same point, before the next access is driven.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // Index of each port in the per-port arrays
    localparam int PORT_LT = 0;
    localparam int PORT_RT = 1;
    localparam int NUM_PORTS = 2;

    // Interrupt flag machine states
    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

endpackage

// File: rtl/mbox_decode.sv
// Per-port decode of mailbox accesses into qualified set / clear requests.
module mbox_decode #(
    parameter int AW = 16,
    parameter logic [AW-1:0] OWN_BOX  = '1,
    parameter logic [AW-1:0] PEER_BOX = '0
) (
    input  logic          en,
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic          busy,
    output logic          post_peer,
    output logic          ack_own
);
    logic is_write;
    logic is_read;

    always_comb begin
        // A write strobe wins over a simultaneous read strobe
        is_write  = en && wr;
        is_read   = en && rd && !wr;
        post_peer = is_write && !busy && (addr == PEER_BOX);
        ack_own   = is_read  && !busy && (addr == OWN_BOX);
    end
endmodule

// File: rtl/mbox_flag.sv
// One interrupt flag: two-state machine, output decoded from the state.
module mbox_flag
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic post,
    input  logic ack,
    output logic irq_n
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (post) state_d = FLAG_PENDING;       // POST
            end
            FLAG_PENDING: begin
                if (post)      state_d = FLAG_PENDING;  // REPOST, set wins
                else if (ack)  state_d = FLAG_IDLE;     // ACK
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FLAG_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        irq_n = (state_q == FLAG_IDLE);
    end

    // R8: reset leaves the flag deasserted
    a_r8_reset_idle: assert property (@(posedge clk) rst |=> irq_n);

    // R2 / R3 / R9: a qualified set always leaves the flag asserted
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        post |=> !irq_n);

    // R4: a lone clear releases the flag
    a_r4_ack_release: assert property (@(posedge clk) disable iff (rst)
        (ack && !post) |=> irq_n);

    // R10: without requests the flag holds its value
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!post && !ack) |=> $stable(irq_n));
endmodule

// File: rtl/mbox_irq_top.sv
module mbox_irq_top
    import mbox_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lt_en,
    input  logic          lt_wr,
    input  logic          lt_rd,
    input  logic [AW-1:0] lt_addr,
    input  logic          lt_busy,
    input  logic          rt_en,
    input  logic          rt_wr,
    input  logic          rt_rd,
    input  logic [AW-1:0] rt_addr,
    input  logic          rt_busy,
    output logic          lt_irq_n,
    output logic          rt_irq_n
);
    // R1: mailbox locations derived from the address width
    localparam logic [AW-1:0] RT_BOX = {AW{1'b1}};
    localparam logic [AW-1:0] LT_BOX = RT_BOX - 1'b1;

    logic          en_a   [NUM_PORTS];
    logic          wr_a   [NUM_PORTS];
    logic          rd_a   [NUM_PORTS];
    logic [AW-1:0] addr_a [NUM_PORTS];
    logic          busy_a [NUM_PORTS];
    logic          post_a [NUM_PORTS];
    logic          ack_a  [NUM_PORTS];
    logic          irq_a  [NUM_PORTS];

    always_comb begin
        en_a[PORT_LT]   = lt_en;   en_a[PORT_RT]   = rt_en;
        wr_a[PORT_LT]   = lt_wr;   wr_a[PORT_RT]   = rt_wr;
        rd_a[PORT_LT]   = lt_rd;   rd_a[PORT_RT]   = rt_rd;
        addr_a[PORT_LT] = lt_addr; addr_a[PORT_RT] = rt_addr;
        busy_a[PORT_LT] = lt_busy; busy_a[PORT_RT] = rt_busy;
        lt_irq_n = irq_a[PORT_LT];
        rt_irq_n = irq_a[PORT_RT];
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        localparam logic [AW-1:0] OWN  = (g == PORT_RT) ? RT_BOX : LT_BOX;
        localparam logic [AW-1:0] PEER = (g == PORT_RT) ? LT_BOX : RT_BOX;
        localparam int            OTHER = NUM_PORTS - 1 - g;

        mbox_decode #(.AW(AW), .OWN_BOX(OWN), .PEER_BOX(PEER)) u_dec (
            .en        (en_a[g]),
            .wr        (wr_a[g]),
            .rd        (rd_a[g]),
            .addr      (addr_a[g]),
            .busy      (busy_a[g]),
            .post_peer (post_a[g]),
            .ack_own   (ack_a[g])
        );

        // Flag g is set by the other port's write and cleared by its own read
        mbox_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .post  (post_a[OTHER]),
            .ack   (ack_a[g]),
            .irq_n (irq_a[g])
        );
    end

    // R6: a busy left writer cannot raise the right flag
    a_r6_busy_blocks_set: assert property (@(posedge clk) disable iff (rst)
        (lt_en && lt_wr && lt_busy && lt_addr == RT_BOX && rt_irq_n) |=> rt_irq_n);

    // R7: a busy right reader cannot drop its own flag
    a_r7_busy_blocks_clear: assert property (@(posedge clk) disable iff (rst)
        (rt_en && rt_rd && !rt_wr && rt_busy && rt_addr == RT_BOX && !rt_irq_n)
        |=> !rt_irq_n);

    // R5: the right port reading the left mailbox never clears the left flag
    a_r5_peer_read_keeps: assert property (@(posedge clk) disable iff (rst)
        (!lt_irq_n && !(lt_en && lt_rd && lt_addr == LT_BOX)) |=> !lt_irq_n);
endmodule

// File: tb/tb_mbox_irq_top.sv
module tb_mbox_irq_top;
    localparam int AW = 16;
    localparam logic [AW-1:0] RB = 16'hFFFF;
    localparam logic [AW-1:0] LB = 16'hFFFE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lt_en = 0, lt_wr = 0, lt_rd = 0, lt_busy = 0;
    logic rt_en = 0, rt_wr = 0, rt_rd = 0, rt_busy = 0;
    logic [AW-1:0] lt_addr = '0, rt_addr = '0;
    logic lt_irq_n, rt_irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mbox_irq_top #(.AW(AW)) dut (
        .clk(clk), .rst(rst),
        .lt_en(lt_en), .lt_wr(lt_wr), .lt_rd(lt_rd), .lt_addr(lt_addr), .lt_busy(lt_busy),
        .rt_en(rt_en), .rt_wr(rt_wr), .rt_rd(rt_rd), .rt_addr(rt_addr), .rt_busy(rt_busy),
        .lt_irq_n(lt_irq_n), .rt_irq_n(rt_irq_n)
    );

    task automatic check(string req, logic got_l, logic got_r, logic exp_l, logic exp_r);
        checks++;
        if (got_l !== exp_l || got_r !== exp_r) begin
            failures++;
            $display("FAIL %s: lt_irq_n=%b rt_irq_n=%b expected lt=%b rt=%b",
                     req, got_l, got_r, exp_l, exp_r);
        end
    endtask

    task automatic idle_inputs();
        lt_en = 0; lt_wr = 0; lt_rd = 0; lt_busy = 0; lt_addr = '0;
        rt_en = 0; rt_wr = 0; rt_rd = 0; rt_busy = 0; rt_addr = '0;
    endtask

    // One-cycle access on both ports; the result is sampled one clock later
    task automatic access(
        input logic le, input logic lw, input logic lr, input logic [AW-1:0] la, input logic lb,
        input logic re, input logic rw, input logic rr, input logic [AW-1:0] ra, input logic rb);
        @(negedge clk);
        lt_en = le; lt_wr = lw; lt_rd = lr; lt_addr = la; lt_busy = lb;
        rt_en = re; rt_wr = rw; rt_rd = rr; rt_addr = ra; rt_busy = rb;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        check("R8 reset state", lt_irq_n, rt_irq_n, 1, 1);
        repeat (2) @(negedge clk);
        check("R8 idle stays high", lt_irq_n, rt_irq_n, 1, 1);
    endtask

    task automatic t_set_and_clear();
        access(1,1,0,RB,0, 0,0,0,'0,0);
        check("R2 R1 left write right box", lt_irq_n, rt_irq_n, 1, 0);
        access(1,0,1,RB,0, 0,0,0,'0,0);
        check("R5 left reads right box", lt_irq_n, rt_irq_n, 1, 0);
        access(0,0,0,'0,0, 1,0,1,RB,1);
        check("R7 busy owner read", lt_irq_n, rt_irq_n, 1, 0);
        access(0,0,0,'0,0, 1,0,1,RB,0);
        check("R4 right reads own box", lt_irq_n, rt_irq_n, 1, 1);
        access(0,0,0,'0,0, 1,1,0,LB,0);
        check("R3 R1 right write left box", lt_irq_n, rt_irq_n, 0, 1);
        access(0,0,0,'0,0, 1,0,1,LB,0);
        check("R5 right reads left box", lt_irq_n, rt_irq_n, 0, 1);
        access(1,0,1,LB,1, 0,0,0,'0,0);
        check("R7 busy left read", lt_irq_n, rt_irq_n, 0, 1);
        access(1,0,1,LB,0, 0,0,0,'0,0);
        check("R4 left reads own box", lt_irq_n, rt_irq_n, 1, 1);
    endtask

    task automatic t_busy_set();
        access(1,1,0,RB,1, 0,0,0,'0,0);
        check("R6 busy left write", lt_irq_n, rt_irq_n, 1, 1);
        access(0,0,0,'0,0, 1,1,0,LB,1);
        check("R6 busy right write", lt_irq_n, rt_irq_n, 1, 1);
    endtask

    task automatic t_ignored();
        access(1,1,0,LB,0, 1,1,0,RB,0);
        check("R10 writes to own boxes", lt_irq_n, rt_irq_n, 1, 1);
        access(1,1,0,16'hFFFD,0, 1,1,0,16'h0000,0);
        check("R10 other addresses", lt_irq_n, rt_irq_n, 1, 1);
        access(0,1,0,RB,0, 0,1,0,LB,0);
        check("R10 enable low", lt_irq_n, rt_irq_n, 1, 1);
        access(1,1,0,RB,0, 1,1,0,LB,0);
        check("R2 R3 both set", lt_irq_n, rt_irq_n, 0, 0);
        access(1,1,0,LB,0, 1,1,0,RB,0);
        check("R10 own-box write keeps flags", lt_irq_n, rt_irq_n, 0, 0);
        access(1,0,1,16'h1234,0, 0,0,1,RB,0);
        check("R10 no clear off-box or disabled", lt_irq_n, rt_irq_n, 0, 0);
    endtask

    task automatic t_wr_and_rd();
        access(1,1,1,LB,0, 1,1,1,RB,0);
        check("R11 write+read on own box", lt_irq_n, rt_irq_n, 0, 0);
        access(1,0,1,LB,0, 1,0,1,RB,0);
        check("R4 both clear", lt_irq_n, rt_irq_n, 1, 1);
    endtask

    task automatic t_same_cycle();
        access(1,1,0,RB,0, 1,0,1,RB,0);
        check("R9 set and clear from idle", lt_irq_n, rt_irq_n, 1, 0);
        access(1,1,0,RB,0, 1,0,1,RB,0);
        check("R9 set and clear while pending", lt_irq_n, rt_irq_n, 1, 0);
        access(1,0,1,LB,0, 1,1,0,LB,0);
        check("R9 left flag set wins", lt_irq_n, rt_irq_n, 0, 0);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R8 reset clears pending", lt_irq_n, rt_irq_n, 1, 1);
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_set_and_clear();
        t_busy_set();
        t_ignored();
        t_wr_and_rd();
        t_same_cycle();
        t_reset_mid();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule